// File: doc/BRIEF.md
# L2 Fill Distribution Sequencer

The sequencer finishes the fill that follows a read of main memory. A pulse on `mem_done_i` marks a completed memory request. The pulse carries the block address and the index of the L2 miss-tracking entry that owns the request. A fixed transit delay later, the returning block becomes available at the L2 controller. In that one cycle the sequencer does three things in a fixed logical order. It inserts the block into the L2. It distributes the block to every L1 whose single outstanding miss is waiting for it. It releases the L2 tracking entry.

The sequencer chooses each filled L1's coherence state from that L1's pending access and from how many L1s wait on the block. A filled L1 can evict a dirty line. When the L2 holds that line, the sequencer reports it so the L2 dirty bit can be set. Lines that the L2 insertion itself displaces are dropped silently.

Every filled L1 then runs a private countdown. When the countdown expires, the sequencer pulses that L1's unstall output, which also frees its miss entry. While its countdown runs, an L1 takes no part in another fill. Successive fills are pipelined, so one can arrive in every cycle.

Top module: `fill_seq`

## Requirements
- R1: `l2_ins_o` is high in the cycle that follows exactly FILL_DLY (5) clock edges after a cycle with `mem_done_i` high, and `l2_ins_addr_o` carries that request's address.
- R2: In the cycle of R1, `l1_ins_o[i]` is high for each L1 i that meets three conditions: its miss entry is valid, its entry address equals the fill address, and it is not held (R9). `l1_ins_addr_o` equals the fill address.
- R3: An inserted L1 whose pending access is a write (`l1_mshr_wr_i[i]`=1) receives state Modified, code 3 on `l1_ins_state_o[i]`.
- R4: An inserted L1 with a pending read receives Exclusive (code 2) when it is the only L1 inserted for that fill.
- R5: An inserted L1 with a pending read receives Shared (code 1) when two or more L1s are inserted for that fill. Lanes that are not inserted report Invalid (code 0).
- R6: `wb_o[i]` is high only when all of the following hold: L1 i is inserted, `l1_evict_vld_i[i]`=1, `l1_evict_mod_i[i]`=1 and `l1_evict_in_l2_i[i]`=1. In that case `wb_addr_o[i]` equals `l1_evict_addr_i[i]`. No other writeback request exists; L2 victims in particular produce none.
- R7: `mshr_free_o` is high in the cycle of R1, and `mshr_free_idx_o` carries the request's L2 entry index.
- R8: `unstall_o[i]` is high for exactly one cycle, UNSTALL_DLY (5) cycles after the cycle in which `l1_ins_o[i]` was high.
- R9: An L1 is held from its insertion cycle through its unstall cycle. A held L1 is not inserted by another fill, even when its entry address matches.
- R10: A fill that matches no L1 still raises `l2_ins_o` and `mshr_free_o`, but raises no `l1_ins_o` and no `wb_o` bit.
- R11: Fills whose `mem_done_i` pulses fall in consecutive cycles complete in consecutive cycles. Each completion carries its own address and entry index.
- R12: After reset, all outputs are low while no fill is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_done_i | input | 1 | Memory request completed |
| mem_addr_i | input | AW | Block address of the completed request |
| mem_mshr_i | input | IW | L2 miss entry index of the request |
| l1_mshr_vld_i | input | N_L1 | Per-L1 miss entry valid |
| l1_mshr_wr_i | input | N_L1 | Per-L1 pending access is a write |
| l1_mshr_addr_i | input | N_L1 x AW | Per-L1 pending block address |
| l1_evict_vld_i | input | N_L1 | Per-L1 insertion displaces a line |
| l1_evict_mod_i | input | N_L1 | Displaced line is Modified |
| l1_evict_addr_i | input | N_L1 x AW | Displaced line address |
| l1_evict_in_l2_i | input | N_L1 | Displaced line is present in L2 |
| l2_ins_o | output | 1 | Insert block into L2 |
| l2_ins_addr_o | output | AW | L2 insertion address |
| l1_ins_o | output | N_L1 | Per-L1 insert command |
| l1_ins_state_o | output | N_L1 x 2 | Per-L1 inserted state (0 I, 1 S, 2 E, 3 M) |
| l1_ins_addr_o | output | AW | L1 insertion address |
| wb_o | output | N_L1 | Per-L1 writeback, sets L2 dirty bit |
| wb_addr_o | output | N_L1 x AW | Writeback address |
| mshr_free_o | output | 1 | Release L2 miss entry |
| mshr_free_idx_o | output | IW | Index of the released entry |
| unstall_o | output | N_L1 | Per-L1 unstall and miss entry release |

## Verification
The key overlap is a fill landing in the same cycle as another L1's unstall pulse from an earlier fill. A second overlap is a fill whose address matches an L1 that is still counting down. The bench provokes the first case as follows. It fills one L1, then schedules a fill for a second L1 so that the new fill lands exactly five cycles after the first insertion. In that cycle it requires the unstall pulse for the first L1 and the Exclusive insertion into the second. It also repeats a fill to the held L1 two cycles after the first one, and in that cycle it requires only the L2 insertion and the entry release. A sweep over every mix of no request, read, write and mismatched address across four L1s covers the rest. For each mix, the bench computes the expected states and writebacks arithmetically.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } coh_state_e;
endpackage

// File: rtl/fill_delay_line.sv
module fill_delay_line #(
  parameter int AW    = 26,
  parameter int IW    = 3,
  parameter int DEPTH = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic [IW-1:0] idx_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [IW-1:0] idx_o
);
  typedef struct packed {
    logic          vld;
    logic [AW-1:0] addr;
    logic [IW-1:0] idx;
  } stage_t;

  stage_t pipe_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[k] <= '0;
        else         pipe_q[k] <= '{vld: vld_i, addr: addr_i, idx: idx_i};
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[k] <= '0;
        else         pipe_q[k] <= pipe_q[k-1];
      end
    end
  end

  assign vld_o  = pipe_q[DEPTH-1].vld;
  assign addr_o = pipe_q[DEPTH-1].addr;
  assign idx_o  = pipe_q[DEPTH-1].idx;
endmodule

// File: rtl/fill_state_calc.sv
module fill_state_calc
  import fill_pkg::*;
#(
  parameter int N_L1 = 4,
  parameter int AW   = 26
) (
  input  logic                     fill_vld_i,
  input  logic [AW-1:0]            fill_addr_i,
  input  logic [N_L1-1:0]          mshr_vld_i,
  input  logic [N_L1-1:0]          mshr_wr_i,
  input  logic [N_L1-1:0][AW-1:0]  mshr_addr_i,
  input  logic [N_L1-1:0]          held_i,
  output logic [N_L1-1:0]          ins_o,
  output coh_state_e [N_L1-1:0]    state_o
);
  localparam int CW = $clog2(N_L1 + 1);

  logic [N_L1-1:0] match;
  logic [CW-1:0]   n_wait;

  for (genvar i = 0; i < N_L1; i++) begin : g_match
    assign match[i] = fill_vld_i & mshr_vld_i[i] & ~held_i[i] &
                      (mshr_addr_i[i] == fill_addr_i);
  end

  always_comb begin
    n_wait = '0;
    for (int i = 0; i < N_L1; i++) n_wait = n_wait + CW'(match[i]);
  end

  for (genvar i = 0; i < N_L1; i++) begin : g_state
    always_comb begin
      if (!match[i])                  state_o[i] = ST_INV;
      else if (mshr_wr_i[i])          state_o[i] = ST_MOD;
      else if (n_wait == CW'(1))      state_o[i] = ST_EXC;
      else                            state_o[i] = ST_SHR;
    end
  end

  assign ins_o = match;
endmodule

// File: rtl/unstall_timer.sv
module unstall_timer #(
  parameter int DLY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int CNT_W = $clog2(DLY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(DLY);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int N_L1        = 4,
  parameter int AW          = 26,
  parameter int IW          = 3,
  parameter int FILL_DLY    = 5,
  parameter int UNSTALL_DLY = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mem_done_i,
  input  logic [AW-1:0]            mem_addr_i,
  input  logic [IW-1:0]            mem_mshr_i,
  input  logic [N_L1-1:0]          l1_mshr_vld_i,
  input  logic [N_L1-1:0]          l1_mshr_wr_i,
  input  logic [N_L1-1:0][AW-1:0]  l1_mshr_addr_i,
  input  logic [N_L1-1:0]          l1_evict_vld_i,
  input  logic [N_L1-1:0]          l1_evict_mod_i,
  input  logic [N_L1-1:0][AW-1:0]  l1_evict_addr_i,
  input  logic [N_L1-1:0]          l1_evict_in_l2_i,
  output logic                     l2_ins_o,
  output logic [AW-1:0]            l2_ins_addr_o,
  output logic [N_L1-1:0]          l1_ins_o,
  output logic [N_L1-1:0][1:0]     l1_ins_state_o,
  output logic [AW-1:0]            l1_ins_addr_o,
  output logic [N_L1-1:0]          wb_o,
  output logic [N_L1-1:0][AW-1:0]  wb_addr_o,
  output logic                     mshr_free_o,
  output logic [IW-1:0]            mshr_free_idx_o,
  output logic [N_L1-1:0]          unstall_o
);
  logic                    fill_vld;
  logic [AW-1:0]           fill_addr;
  logic [IW-1:0]           fill_idx;
  logic [N_L1-1:0]         held;
  logic [N_L1-1:0]         ins;
  coh_state_e [N_L1-1:0]   state;

  fill_delay_line #(.AW(AW), .IW(IW), .DEPTH(FILL_DLY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (mem_done_i),
    .addr_i (mem_addr_i),
    .idx_i  (mem_mshr_i),
    .vld_o  (fill_vld),
    .addr_o (fill_addr),
    .idx_o  (fill_idx)
  );

  fill_state_calc #(.N_L1(N_L1), .AW(AW)) u_calc (
    .fill_vld_i  (fill_vld),
    .fill_addr_i (fill_addr),
    .mshr_vld_i  (l1_mshr_vld_i),
    .mshr_wr_i   (l1_mshr_wr_i),
    .mshr_addr_i (l1_mshr_addr_i),
    .held_i      (held),
    .ins_o       (ins),
    .state_o     (state)
  );

  for (genvar i = 0; i < N_L1; i++) begin : g_lane
    unstall_timer #(.DLY(UNSTALL_DLY)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (ins[i]),
      .busy_o   (held[i]),
      .expire_o (unstall_o[i])
    );
    // L2 victims never reach this path; only L1 victims resident in L2 are reported
    assign wb_o[i]           = ins[i] & l1_evict_vld_i[i] & l1_evict_mod_i[i] & l1_evict_in_l2_i[i];
    assign wb_addr_o[i]      = l1_evict_addr_i[i];
    assign l1_ins_state_o[i] = state[i];
  end

  // logical order within the fill cycle: L2 insert, L1 inserts, entry release
  assign l2_ins_o        = fill_vld;
  assign l2_ins_addr_o   = fill_addr;
  assign l1_ins_o        = ins;
  assign l1_ins_addr_o   = fill_addr;
  assign mshr_free_o     = fill_vld;
  assign mshr_free_idx_o = fill_idx;
endmodule

// File: rtl/fill_seq_chk.sv
module fill_seq_chk #(
  parameter int N_L1        = 4,
  parameter int UNSTALL_DLY = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 l2_ins_o,
  input logic                 mshr_free_o,
  input logic [N_L1-1:0]      l1_ins_o,
  input logic [N_L1-1:0][1:0] l1_ins_state_o,
  input logic [N_L1-1:0]      wb_o,
  input logic [N_L1-1:0]      l1_evict_mod_i,
  input logic [N_L1-1:0]      unstall_o
);
  localparam int CW = $clog2(UNSTALL_DLY + 1);

  p_l1_under_l2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|l1_ins_o) |-> l2_ins_o);

  p_free_with_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mshr_free_o == l2_ins_o);

  for (genvar i = 0; i < N_L1; i++) begin : g_chk
    logic [CW-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            age_q <= '0;
      else if (l1_ins_o[i])   age_q <= CW'(UNSTALL_DLY);
      else if (age_q != '0)   age_q <= age_q - CW'(1);
    end

    p_unstall_timing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unstall_o[i] |-> (age_q == CW'(1)));

    p_unstall_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == CW'(1)) |-> unstall_o[i]);

    p_no_ins_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1_ins_o[i] |-> (age_q == '0));

    p_wb_needs_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_o[i] |-> (l1_ins_o[i] && l1_evict_mod_i[i]));

    p_exc_alone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1_ins_state_o[i] == 2'd2) |-> ($countones(l1_ins_o) == 1));

    p_state_iff_ins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l1_ins_state_o[i] != 2'd0) == l1_ins_o[i]);
  end
endmodule

bind fill_seq fill_seq_chk #(.N_L1(N_L1), .UNSTALL_DLY(UNSTALL_DLY)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .l2_ins_o       (l2_ins_o),
  .mshr_free_o    (mshr_free_o),
  .l1_ins_o       (l1_ins_o),
  .l1_ins_state_o (l1_ins_state_o),
  .wb_o           (wb_o),
  .l1_evict_mod_i (l1_evict_mod_i),
  .unstall_o      (unstall_o)
);

// File: tb/sim_fill_seq.sv
module sim_fill_seq;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               mem_done;
  logic [AW-1:0]      mem_addr;
  logic [IW-1:0]      mem_mshr;
  logic [N-1:0]       m_vld, m_wr, ev_vld, ev_mod, ev_l2;
  logic [N-1:0][AW-1:0] m_addr, ev_addr;
  logic               l2_ins, mshr_free;
  logic [AW-1:0]      l2_addr, l1_addr;
  logic [N-1:0]       l1_ins, wb, unstall;
  logic [N-1:0][1:0]  st;
  logic [N-1:0][AW-1:0] wb_addr;
  logic [IW-1:0]      free_idx;

  fill_seq #(.N_L1(N), .AW(AW), .IW(IW), .FILL_DLY(5), .UNSTALL_DLY(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_done_i(mem_done), .mem_addr_i(mem_addr), .mem_mshr_i(mem_mshr),
    .l1_mshr_vld_i(m_vld), .l1_mshr_wr_i(m_wr), .l1_mshr_addr_i(m_addr),
    .l1_evict_vld_i(ev_vld), .l1_evict_mod_i(ev_mod), .l1_evict_addr_i(ev_addr),
    .l1_evict_in_l2_i(ev_l2),
    .l2_ins_o(l2_ins), .l2_ins_addr_o(l2_addr), .l1_ins_o(l1_ins),
    .l1_ins_state_o(st), .l1_ins_addr_o(l1_addr), .wb_o(wb), .wb_addr_o(wb_addr),
    .mshr_free_o(mshr_free), .mshr_free_idx_o(free_idx), .unstall_o(unstall)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [AW-1:0] a, input logic [IW-1:0] idx);
    mem_done = 1'b1; mem_addr = a; mem_mshr = idx;
  endtask

  task automatic idle();
    mem_done = 1'b0; mem_addr = '0; mem_mshr = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    idle();
    m_vld = '0; m_wr = '0; m_addr = '0;
    ev_vld = '0; ev_mod = '0; ev_l2 = '0; ev_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    check(!l2_ins && !mshr_free && l1_ins == '0 && wb == '0 && unstall == '0, "R12",
          {l2_ins, mshr_free, l1_ins, wb, unstall}, 0);

    // sweep: per L1 0 none, 1 read A, 2 write A, 3 read other block
    for (int k = 0; k < 256; k++) begin
      logic [AW-1:0] a;
      logic [N-1:0] exp_ins, exp_wb;
      int n_wait;
      a = AW'(k * 7 + 3);
      n_wait = 0;
      exp_ins = '0;
      for (int i = 0; i < N; i++) begin
        int opt;
        int e;
        opt = (k >> (2 * i)) & 3;
        m_vld[i] = (opt != 0);
        m_wr[i]  = (opt == 2);
        m_addr[i] = (opt == 3) ? (a ^ AW'(1)) : a;
        e = (k * 5 + i * 3) & 7;
        ev_vld[i] = e[0]; ev_mod[i] = e[1]; ev_l2[i] = e[2];
        ev_addr[i] = AW'(a + AW'(16 + i));
        if (opt == 1 || opt == 2) begin n_wait++; exp_ins[i] = 1'b1; end
      end
      exp_wb = exp_ins & ev_vld & ev_mod & ev_l2;
      for (int t = 0; t < 14; t++) begin
        if (t == 5) begin
          check(l2_ins && l2_addr == a, "R1", {l2_ins, l2_addr}, {1'b1, a});
          check(mshr_free && free_idx == IW'(k), "R7", {mshr_free, free_idx}, {1'b1, IW'(k)});
          check(l1_ins == exp_ins && l1_addr == a, exp_ins == '0 ? "R10" : "R2",
                {l1_ins, l1_addr}, {exp_ins, a});
          for (int i = 0; i < N; i++) begin
            int opt;
            logic [1:0] es;
            opt = (k >> (2 * i)) & 3;
            es = (opt == 2) ? 2'd3 : (opt == 1 && n_wait == 1) ? 2'd2 : (opt == 1) ? 2'd1 : 2'd0;
            check(st[i] == es, es == 2'd3 ? "R3" : es == 2'd2 ? "R4" : "R5", st[i], es);
          end
          check(wb == exp_wb, "R6", wb, exp_wb);
          for (int i = 0; i < N; i++)
            if (exp_wb[i]) check(wb_addr[i] == ev_addr[i], "R6", wb_addr[i], ev_addr[i]);
        end
        if (t == 9)  check(unstall == '0, "R8", unstall, 0);
        if (t == 10) check(unstall == exp_ins, "R8", unstall, exp_ins);
        if (t == 11) check(unstall == '0 && !l2_ins, "R8", unstall, 0);
        if (t == 0) fire(a, IW'(k)); else idle();
        @(negedge clk);
      end
    end

    // held L1 and coincident fill/unstall
    m_vld = 4'b0011; m_wr = '0;
    m_addr[0] = 8'h40; m_addr[1] = 8'h50; m_addr[2] = 8'h00; m_addr[3] = 8'h00;
    ev_vld = '0; ev_mod = '0; ev_l2 = '0;
    for (int t = 0; t < 16; t++) begin
      if (t == 5) check(l1_ins == 4'b0001 && st[0] == 2'd2, "R4", {l1_ins, st[0]}, {4'b0001, 2'd2});
      if (t == 7) begin
        check(l2_ins && mshr_free && free_idx == 2'd1, "R10", {l2_ins, mshr_free, free_idx}, 4'b1101);
        check(l1_ins == '0, "R9", l1_ins, 0);
      end
      if (t == 10) begin
        check(unstall == 4'b0001, "R8", unstall, 4'b0001);
        check(l1_ins == 4'b0010 && st[1] == 2'd2 && l1_addr == 8'h50, "R2",
              {l1_ins, st[1], l1_addr}, {4'b0010, 2'd2, 8'h50});
      end
      if (t == 15) check(unstall == 4'b0010, "R8", unstall, 4'b0010);
      case (t)
        0: fire(8'h40, 2'd0);
        2: fire(8'h40, 2'd1);
        5: fire(8'h50, 2'd2);
        default: idle();
      endcase
      @(negedge clk);
    end

    // back-to-back fills
    m_vld = 4'b1100; m_wr = 4'b1000;
    m_addr[2] = 8'h21; m_addr[3] = 8'h77;
    ev_vld = 4'b1000; ev_mod = 4'b1000; ev_l2 = 4'b1000; ev_addr[3] = 8'h9a;
    for (int t = 0; t < 14; t++) begin
      if (t == 5) check(l1_ins == 4'b0100 && st[2] == 2'd2 && free_idx == 2'd1 && l2_addr == 8'h21,
                        "R11", {l1_ins, st[2], free_idx, l2_addr}, {4'b0100, 2'd2, 2'd1, 8'h21});
      if (t == 6) begin
        check(l1_ins == 4'b1000 && st[3] == 2'd3 && free_idx == 2'd2 && l2_addr == 8'h77,
              "R11", {l1_ins, st[3], free_idx, l2_addr}, {4'b1000, 2'd3, 2'd2, 8'h77});
        check(wb == 4'b1000 && wb_addr[3] == 8'h9a, "R6", {wb, wb_addr[3]}, {4'b1000, 8'h9a});
      end
      if (t == 10) check(unstall == 4'b0100, "R11", unstall, 4'b0100);
      if (t == 11) check(unstall == 4'b1000, "R11", unstall, 4'b1000);
      case (t)
        0: fire(8'h21, 2'd1);
        1: fire(8'h77, 2'd2);
        default: idle();
      endcase
      @(negedge clk);
    end

    finish_run();
  end
endmodule